// File: doc/BRIEF.md
# Set-Associative Translation Buffer Command Engine

This block holds a joint address translation buffer organised as a number of sets, each with a fixed number of ways. Software drives it through four registers: a tag word (virtual page, present flag, address-space ID), a frame word (physical frame and permissions, stored opaquely), an index register and a command register. Writing a command code starts one operation. The engine runs it over a fixed number of cycles and then leaves its result in the registers or in the entry storage.

The operations search a set for a translation, allocate a slot for a new translation, store or fetch an entry at a linear index, and invalidate the small per-port translation caches that sit downstream. Those caches are not part of this block. It only emits a one-cycle invalidate pulse toward them.

Tag word layout: bits [31:PAGE_BITS] hold the virtual page number, bit 8 is the present flag, and bits [7:0] hold the address-space ID. The low SET_W bits of the virtual page number select the set. Command codes in bits [2:0] of a command write are: 1 probe, 2 write with invalidate, 3 write keeping the small caches, 4 read, 5 get-index, 6 invalidate small caches. Codes 0 and 7 are reserved.

Top module: `tlb_cmd_engine`

## Requirements
- R1: An entry's linear index is set × WAYS + way, so the ways of one set sit at consecutive indices. A software write to the index register keeps only the low IDX_W bits and clears bit 31.
- R2: Probe compares the virtual page and the address-space ID of the tag register against every present way of the selected set. On a single match it loads the index register with that entry's linear index, with bit 31 clear.
- R3: Probe with no match, including a match only against entries whose present bit is 0, loads the index register with 0x8000_0000, where bit 31 is the lookup-error flag.
- R4: Probe matching more than one way loads the index register with 0x8000_0001, meaning lookup error plus duplicate.
- R5: Both write commands store the tag and frame words at the entry named by the index register. An entry written with zero words no longer matches a probe.
- R6: Command 2 and command 6 each raise utlb_inv for exactly one cycle, in the cycle after busy falls. Command 3 and every other command leave it low.
- R7: Read loads the tag and frame registers from the entry named by the index register.
- R8: Get-index loads the index register with the lowest way of the tag's set whose present bit is 0.
- R9: When every way of the set is present, get-index uses that set's round-robin pointer and then advances it. Each set keeps its own pointer, which starts at way 0.
- R10: An accepted command holds busy high for exactly CMD_CYCLES cycles. Register and command writes made while busy is high have no effect.
- R11: After reset the tag, frame and index registers are zero, busy and utlb_inv are low, and no entry is present.
- R12: A command write with a reserved code (0 or 7) starts nothing: busy stays low and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 tag, 1 frame, 2 index, 3 command |
| reg_wdata | input | 32 | Register write data |
| tag_word | output | 32 | Current tag register |
| frame_word | output | 32 | Current frame register |
| index_word | output | 32 | Current index register, bit 31 lookup error |
| busy | output | 1 | Command in progress |
| utlb_inv | output | 1 | One-cycle invalidate pulse toward the small translation caches |

## Verification
Probe is tried with an exact hit, with the same page under a different address-space ID, and with a matching page whose present bit is clear. These cases separate a comparison that ignores the ID or the present flag from a correct one. A set holding the same translation in two ways tells duplicate reporting apart from a plain first-match hit. Get-index is run on a partly filled set, an empty set and a full set, and is then repeated on the full set, which tells the free-slot scan apart from the round-robin pointer and shows that the pointer advances. Writes to registers made while a command is running, and reserved command codes, show that input is correctly ignored.

// File: rtl/tlbe_pkg.sv
// Shared constants and codes for the translation buffer command engine.
package tlbe_pkg;
    localparam int unsigned PRES_BIT = 8;
    localparam int unsigned ASID_W   = 8;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_PROBE      = 3'd1,
        OP_WRITE      = 3'd2,
        OP_WRITE_KEEP = 3'd3,
        OP_READ       = 3'd4,
        OP_GETIDX     = 3'd5,
        OP_UINV       = 3'd6,
        OP_RSVD       = 3'd7
    } tlbe_op_e;

    typedef enum logic [1:0] {
        SEL_TAG   = 2'd0,
        SEL_FRAME = 2'd1,
        SEL_INDEX = 2'd2,
        SEL_CMD   = 2'd3
    } tlbe_sel_e;
endpackage

// File: rtl/tlbe_store.sv
// Entry storage: two words per entry, one write port, one random read port
// and a read of all ways of one set. Assumes SETS and WAYS are powers of two
// and WAYS >= 2, so the linear index is {set, way}.
module tlbe_store #(
    parameter int SETS = 128,
    parameter int WAYS = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [$clog2(SETS*WAYS)-1:0]        wr_idx,
    input  logic [31:0]                         wr_w0,
    input  logic [31:0]                         wr_w1,
    input  logic [$clog2(SETS*WAYS)-1:0]        rd_idx,
    output logic [31:0]                         rd_w0,
    output logic [31:0]                         rd_w1,
    input  logic [$clog2(SETS)-1:0]             set_sel,
    output logic [WAYS-1:0][31:0]               set_w0
);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int ENTRIES = SETS * WAYS;

    logic [31:0] mem0 [ENTRIES];
    logic [31:0] mem1 [ENTRIES];

    // Clear all entries on reset, otherwise store on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem0[i] <= '0;
                mem1[i] <= '0;
            end
        end else if (wr_en) begin
            mem0[wr_idx] <= wr_w0;
            mem1[wr_idx] <= wr_w1;
        end
    end

    assign rd_w0 = mem0[rd_idx];
    assign rd_w1 = mem1[rd_idx];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign set_w0[w] = mem0[{set_sel, WAY_W'(w)}];
    end
endmodule

// File: rtl/tlbe_match.sv
// Compares a search key against every way of one set. Reports which ways are
// present, whether any present way matches, whether more than one matches,
// and the lowest matching way.
module tlbe_match
    import tlbe_pkg::*;
#(
    parameter int WAYS      = 2,
    parameter int PAGE_BITS = 13
) (
    input  logic [WAYS-1:0][31:0]       set_w0,
    input  logic [31:0]                 key,
    output logic [WAYS-1:0]             valid_vec,
    output logic                        hit_any,
    output logic                        hit_dup,
    output logic [$clog2(WAYS)-1:0]     hit_way
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAYS-1:0] hit_vec;
    logic [WAY_W:0]  hit_cnt;
    logic            unused_key;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign valid_vec[w] = set_w0[w][PRES_BIT];
        assign hit_vec[w]   = valid_vec[w]
                            && (set_w0[w][31:PAGE_BITS] == key[31:PAGE_BITS])
                            && (set_w0[w][ASID_W-1:0] == key[ASID_W-1:0]);
    end

    // Count matches and pick the lowest matching way.
    always_comb begin
        hit_cnt = '0;
        hit_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_way = WAY_W'(i);
                hit_cnt = hit_cnt + 1'b1;
            end
        end
    end

    assign hit_any    = (hit_cnt != '0);
    assign hit_dup    = (hit_cnt > 1);
    assign unused_key = ^{key[PAGE_BITS-1:ASID_W], set_w0};
endmodule

// File: rtl/tlbe_victim.sv
// Slot choice for a new entry: lowest non-present way, else a per-set
// round-robin pointer that moves on each time it is used.
module tlbe_victim #(
    parameter int SETS = 128,
    parameter int WAYS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(SETS)-1:0]     set_sel,
    input  logic [WAYS-1:0]             valid_vec,
    input  logic                        advance,
    output logic [$clog2(WAYS)-1:0]     pick_way
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAY_W-1:0] rr [SETS];
    logic             all_valid;

    assign all_valid = &valid_vec;

    // Lowest free way wins, otherwise the set's pointer.
    always_comb begin
        pick_way = rr[set_sel];
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid_vec[i]) pick_way = WAY_W'(i);
        end
    end

    // Move the set's pointer on after it has chosen a victim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rr[s] <= '0;
        end else if (advance && all_valid) begin
            rr[set_sel] <= rr[set_sel] + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_cmd_engine.sv
// Command engine for a set-associative translation buffer. Holds the
// software-visible registers, accepts one command at a time, counts
// CMD_CYCLES busy cycles and applies the result on the last one.
// Assumes power-of-two SETS and WAYS, WAYS >= 2, CMD_CYCLES >= 1.
module tlb_cmd_engine
    import tlbe_pkg::*;
#(
    parameter int SETS       = 128,
    parameter int WAYS       = 2,
    parameter int PAGE_BITS  = 13,
    parameter int CMD_CYCLES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] tag_word,
    output logic [31:0] frame_word,
    output logic [31:0] index_word,
    output logic        busy,
    output logic        utlb_inv
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int IDX_W = SET_W + WAY_W;
    localparam int CNT_W = $clog2(CMD_CYCLES + 1);
    localparam logic [31:0] IDX_MISS = 32'h8000_0000;
    localparam logic [31:0] IDX_DUP  = 32'h8000_0001;

    logic [31:0]           tag_q, frame_q, idx_q;
    logic                  busy_q, inv_q;
    logic [CNT_W-1:0]      cnt_q;
    tlbe_op_e              op_q, new_op;
    logic                  accept, exec, op_ok, wr_en;
    logic [SET_W-1:0]      key_set;
    logic [WAYS-1:0][31:0] set_w0;
    logic [WAYS-1:0]       valid_vec;
    logic                  hit_any, hit_dup;
    logic [WAY_W-1:0]      hit_way, pick_way;
    logic [31:0]           rd_w0, rd_w1;

    assign accept  = reg_we && !busy_q;
    assign exec    = busy_q && (cnt_q == '0);
    assign new_op  = tlbe_op_e'(reg_wdata[2:0]);
    assign op_ok   = (new_op != OP_NONE) && (new_op != OP_RSVD);
    assign key_set = tag_q[PAGE_BITS +: SET_W];
    assign wr_en   = exec && (op_q == OP_WRITE || op_q == OP_WRITE_KEEP);

    tlbe_store #(.SETS(SETS), .WAYS(WAYS)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(idx_q[IDX_W-1:0]),
        .wr_w0(tag_q), .wr_w1(frame_q),
        .rd_idx(idx_q[IDX_W-1:0]), .rd_w0(rd_w0), .rd_w1(rd_w1),
        .set_sel(key_set), .set_w0(set_w0)
    );

    tlbe_match #(.WAYS(WAYS), .PAGE_BITS(PAGE_BITS)) u_match (
        .set_w0(set_w0), .key(tag_q), .valid_vec(valid_vec),
        .hit_any(hit_any), .hit_dup(hit_dup), .hit_way(hit_way)
    );

    tlbe_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
        .clk(clk), .rst_n(rst_n), .set_sel(key_set), .valid_vec(valid_vec),
        .advance(exec && op_q == OP_GETIDX), .pick_way(pick_way)
    );

    // Sequencer: start a valid command when idle, count down, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            op_q   <= OP_NONE;
        end else if (exec) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (accept && reg_sel == SEL_CMD && op_ok) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(CMD_CYCLES - 1);
            op_q   <= new_op;
        end
    end

    // Software registers: command results on the last cycle, writes when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q   <= '0;
            frame_q <= '0;
            idx_q   <= '0;
        end else if (exec) begin
            case (op_q)
                OP_PROBE: begin
                    if (hit_dup)      idx_q <= IDX_DUP;
                    else if (hit_any) idx_q <= {{(32-IDX_W){1'b0}}, key_set, hit_way};
                    else              idx_q <= IDX_MISS;
                end
                OP_READ: begin
                    tag_q   <= rd_w0;
                    frame_q <= rd_w1;
                end
                OP_GETIDX: idx_q <= {{(32-IDX_W){1'b0}}, key_set, pick_way};
                default: ;
            endcase
        end else if (accept) begin
            case (reg_sel)
                SEL_TAG:   tag_q   <= reg_wdata;
                SEL_FRAME: frame_q <= reg_wdata;
                SEL_INDEX: idx_q   <= {{(32-IDX_W){1'b0}}, reg_wdata[IDX_W-1:0]};
                default: ;
            endcase
        end
    end

    // One-cycle invalidate pulse after a plain write or an explicit request.
    always_ff @(posedge clk) begin
        if (!rst_n) inv_q <= 1'b0;
        else        inv_q <= exec && (op_q == OP_WRITE || op_q == OP_UINV);
    end

    assign tag_word   = tag_q;
    assign frame_word = frame_q;
    assign index_word = idx_q;
    assign busy       = busy_q;
    assign utlb_inv   = inv_q;
endmodule

// File: rtl/tlbe_checker.sv
// Protocol checks on the engine's ports, bound into every instance.
module tlbe_checker #(
    parameter int CMD_CYCLES = 2,
    parameter int IDX_W      = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        utlb_inv,
    input logic [31:0] index_word,
    input logic [31:0] tag_word,
    input logic [31:0] frame_word
);
    int unsigned run;

    // Length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n) run <= 0;
        else        run <= busy ? run + 1 : 0;
    end

    p_inv_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        utlb_inv |=> !utlb_inv);
    p_inv_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        utlb_inv |-> ($past(busy) && !busy));
    p_busy_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run < CMD_CYCLES));
    p_busy_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run == CMD_CYCLES));
    p_regs_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(index_word) && $stable(tag_word) && $stable(frame_word)));
    p_err_format_r3: assert property (@(posedge clk) disable iff (!rst_n)
        index_word[31] |-> (index_word[30:1] == 30'd0));
    p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !index_word[31] |-> ((index_word >> IDX_W) == 32'd0));
endmodule

bind tlb_cmd_engine tlbe_checker #(.CMD_CYCLES(CMD_CYCLES), .IDX_W(IDX_W)) u_tlbe_checker (
    .clk(clk), .rst_n(rst_n), .busy(busy), .utlb_inv(utlb_inv),
    .index_word(index_word), .tag_word(tag_word), .frame_word(frame_word)
);

// File: tb/tlb_cmd_engine_bench.sv
// Bench: behavioural reference model compared every cycle, plus directed
// checks with hand-computed values.
module tlb_cmd_engine_bench;
    localparam int SETS = 128;
    localparam int WAYS = 2;
    localparam int PB   = 13;
    localparam int CYC  = 2;
    localparam int ENT  = SETS * WAYS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] tag_word, frame_word, index_word;
    logic        busy, utlb_inv;

    int errors = 0;
    int checks = 0;
    int cyc_n  = 0;
    string cur_req = "R11";

    tlb_cmd_engine #(.SETS(SETS), .WAYS(WAYS), .PAGE_BITS(PB), .CMD_CYCLES(CYC)) u_tlb_cmd_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .tag_word(tag_word), .frame_word(frame_word), .index_word(index_word),
        .busy(busy), .utlb_inv(utlb_inv)
    );

    always #4 clk = ~clk;

    // ---------------- reference model ----------------
    logic [31:0] m_tag, m_frame, m_idx;
    logic [31:0] m_w0 [ENT];
    logic [31:0] m_w1 [ENT];
    int          m_rr [SETS];
    logic        m_busy, m_inv;
    int          m_cnt, m_op;

    task automatic model_exec();
        int s, n, first, e;
        s = int'((m_tag >> PB) % SETS);
        case (m_op)
            1: begin
                n = 0; first = -1;
                for (int w = 0; w < WAYS; w++) begin
                    e = s * WAYS + w;
                    if (m_w0[e][8] && m_w0[e][31:PB] == m_tag[31:PB] && m_w0[e][7:0] == m_tag[7:0]) begin
                        n++;
                        if (first < 0) first = w;
                    end
                end
                if (n == 0)     m_idx = 32'h8000_0000;
                else if (n > 1) m_idx = 32'h8000_0001;
                else            m_idx = 32'(s * WAYS + first);
            end
            2, 3: begin
                m_w0[m_idx % ENT] = m_tag;
                m_w1[m_idx % ENT] = m_frame;
                if (m_op == 2) m_inv = 1'b1;
            end
            4: begin
                m_tag   = m_w0[m_idx % ENT];
                m_frame = m_w1[m_idx % ENT];
            end
            5: begin
                first = -1;
                for (int w = WAYS - 1; w >= 0; w--)
                    if (!m_w0[s * WAYS + w][8]) first = w;
                if (first < 0) begin
                    first = m_rr[s];
                    m_rr[s] = (m_rr[s] + 1) % WAYS;
                end
                m_idx = 32'(s * WAYS + first);
            end
            6: m_inv = 1'b1;
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tag = 0; m_frame = 0; m_idx = 0; m_busy = 0; m_inv = 0; m_cnt = 0; m_op = 0;
            for (int i = 0; i < ENT; i++) begin m_w0[i] = 0; m_w1[i] = 0; end
            for (int i = 0; i < SETS; i++) m_rr[i] = 0;
        end else begin
            m_inv = 1'b0;
            if (m_busy) begin
                if (m_cnt == 0) begin model_exec(); m_busy = 1'b0; end
                else m_cnt--;
            end else if (reg_we) begin
                case (reg_sel)
                    2'd0: m_tag = reg_wdata;
                    2'd1: m_frame = reg_wdata;
                    2'd2: m_idx = reg_wdata % ENT;
                    default: if (reg_wdata[2:0] != 0 && reg_wdata[2:0] != 7) begin
                        m_busy = 1'b1; m_cnt = CYC - 1; m_op = int'(reg_wdata[2:0]);
                    end
                endcase
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cyc_n > 1) begin
            checks++;
            if (busy !== m_busy || utlb_inv !== m_inv || tag_word !== m_tag ||
                frame_word !== m_frame || index_word !== m_idx) begin
                errors++;
                $display("FAIL %s cycle %0d actual busy=%0b inv=%0b tag=%h frame=%h idx=%h expected busy=%0b inv=%0b tag=%h frame=%h idx=%h",
                         cur_req, cyc_n, busy, utlb_inv, tag_word, frame_word, index_word,
                         m_busy, m_inv, m_tag, m_frame, m_idx);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 50000) begin
            errors++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic run_cmd(input logic [2:0] c, output int pulses, output int bcyc);
        wr_reg(2'd3, {29'd0, c});
        pulses = 0; bcyc = 0;
        repeat (CYC + 2) begin
            if (busy) bcyc++;
            if (utlb_inv) pulses++;
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] mk_tag(input int vpn, input int asid, input bit pres);
        return (32'(vpn) << PB) | (32'(pres) << 8) | 32'(asid & 8'hff);
    endfunction

    task automatic put(input logic [31:0] t, input logic [31:0] f, input int idx, input logic [2:0] c);
        int p, b;
        wr_reg(2'd0, t); wr_reg(2'd1, f); wr_reg(2'd2, 32'(idx));
        run_cmd(c, p, b);
    endtask

    initial begin
        int p, b;
        logic [31:0] ta, tc;
        ta = mk_tag(32'h105, 8'h21, 1'b1);
        tc = mk_tag(32'h305, 8'h21, 1'b1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state.
        cur_req = "R11";
        chk("R11 idx", index_word, 32'd0);
        chk("R11 tag", tag_word, 32'd0);
        chk("R11 busy", {31'd0, busy}, 32'd0);
        wr_reg(2'd0, ta); run_cmd(3'd1, p, b);
        chk("R11 probe after reset", index_word, 32'h8000_0000);

        // R5 / R6: plain write pulses once; R10 busy length.
        cur_req = "R5";
        wr_reg(2'd0, ta); wr_reg(2'd1, 32'hABCD_0007); wr_reg(2'd2, 32'd10);
        run_cmd(3'd2, p, b);
        chk("R6 write pulse count", 32'(p), 32'd1);
        chk("R10 busy cycles", 32'(b), 32'(CYC));

        // R2: hit returns set*WAYS+way = 5*2+0 (R1).
        cur_req = "R2";
        run_cmd(3'd1, p, b);
        chk("R2 probe hit", index_word, 32'd10);
        chk("R6 probe no pulse", 32'(p), 32'd0);

        // R3: different address-space ID misses; non-present entry misses.
        cur_req = "R3";
        wr_reg(2'd0, mk_tag(32'h105, 8'h22, 1'b1)); run_cmd(3'd1, p, b);
        chk("R3 asid miss", index_word, 32'h8000_0000);
        put(mk_tag(32'h206, 8'h21, 1'b0), 32'h1, 12, 3'd3);
        chk("R6 keep-write no pulse", 32'(p), 32'd0);
        wr_reg(2'd0, mk_tag(32'h206, 8'h21, 1'b1)); run_cmd(3'd1, p, b);
        chk("R3 not-present miss", index_word, 32'h8000_0000);

        // R8: first free way.
        cur_req = "R8";
        wr_reg(2'd0, mk_tag(32'h405, 8'h01, 1'b1)); run_cmd(3'd5, p, b);
        chk("R8 getidx set5", index_word, 32'd11);
        wr_reg(2'd0, mk_tag(32'h006, 8'h01, 1'b1)); run_cmd(3'd5, p, b);
        chk("R8 getidx set6 way0", index_word, 32'd12);

        // R9: full set uses round robin and advances.
        cur_req = "R9";
        put(tc, 32'h2, 11, 3'd3);
        wr_reg(2'd0, mk_tag(32'h505, 8'h01, 1'b1)); run_cmd(3'd5, p, b);
        chk("R9 rr first", index_word, 32'd10);
        run_cmd(3'd5, p, b);
        chk("R9 rr second", index_word, 32'd11);
        run_cmd(3'd5, p, b);
        chk("R9 rr wrap", index_word, 32'd10);

        // R4: duplicate.
        cur_req = "R4";
        put(ta, 32'h3, 11, 3'd3);
        run_cmd(3'd1, p, b);
        chk("R4 duplicate", index_word, 32'h8000_0001);

        // R5: erase by writing zeros, then single hit again.
        cur_req = "R5";
        put(32'd0, 32'd0, 11, 3'd2);
        wr_reg(2'd0, ta); run_cmd(3'd1, p, b);
        chk("R5 erased way gone", index_word, 32'd10);

        // R7: read back.
        cur_req = "R7";
        wr_reg(2'd0, 32'd0); wr_reg(2'd1, 32'd0); wr_reg(2'd2, 32'd10);
        run_cmd(3'd4, p, b);
        chk("R7 read tag", tag_word, ta);
        chk("R7 read frame", frame_word, 32'hABCD_0007);

        // R6: explicit invalidate.
        cur_req = "R6";
        run_cmd(3'd6, p, b);
        chk("R6 inv pulse", 32'(p), 32'd1);

        // R10: writes during busy ignored.
        cur_req = "R10";
        wr_reg(2'd3, 32'd1);
        wr_reg(2'd0, 32'hDEAD_BEEF);
        wr_reg(2'd3, 32'd6);
        repeat (CYC + 2) @(negedge clk);
        chk("R10 tag unchanged", tag_word, ta);
        chk("R10 no late pulse", {31'd0, utlb_inv}, 32'd0);

        // R12: reserved codes.
        cur_req = "R12";
        run_cmd(3'd7, p, b);
        chk("R12 code7 busy", 32'(b), 32'd0);
        run_cmd(3'd0, p, b);
        chk("R12 code0 busy", 32'(b), 32'd0);
        chk("R12 idx unchanged", index_word, 32'd10);

        // R1: index write keeps low bits, clears flag.
        cur_req = "R1";
        wr_reg(2'd2, 32'hFFFF_FFFF);
        chk("R1 index write", index_word, 32'(ENT - 1));

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule